// File: doc/BRIEF.md
# Serial Byte Receiver with Sticky Error Status

This block takes one asynchronous serial input line, oversamples it at a fixed multiple of the bit rate, and recovers 8-bit characters that arrive least significant bit first. A falling edge on the idle-high line starts a frame. The block resamples the line half a bit later to confirm the start. It then samples every later bit at its centre. An optional parity bit comes after the data bits, and one stop bit ends the frame. The recovered byte goes into a single receive buffer, and the buffer-full flag is set.

Each completed frame is checked for three faults: a parity bit that disagrees with the selected parity rule, a stop bit sampled low, and a new byte arriving while the previous one is still unread. These faults collect in a sticky three-bit status register. The status register clears when the host pulses its read strobe. Each frame produces a one-cycle interrupt pulse. A routing input decides whether a faulty frame pulses the dedicated error interrupt or the ordinary completion interrupt. The host must drain the buffer even after a fault. If it does not, every following frame is flagged as an overrun.

Top module: `uart_rx_err`

## Requirements
- R1: After rst_ni is released, buf_full_o, stat_o, buf_data_o, irq_done_o and irq_err_o are all zero.
- R2: A frame is a low start bit, 8 data bits with bit 0 first, an optional parity bit, and a high stop bit. At completion the byte appears on buf_data_o, buf_full_o goes high, and exactly one interrupt output pulses for a single cycle.
- R3: A low pulse on rx_i that is no longer high-to-low-to-high than a quarter bit is rejected as a false start when the line is resampled at mid start bit. It changes no output.
- R4: parity_mode_i encodes 0 = none, 1 = even (data plus parity hold an even count of ones), 2 = odd, 3 = parity bit forced to 0. A parity bit that breaks the selected rule sets stat_o[0].
- R5: With parity_mode_i = 0 the frame carries no parity bit, so the stop bit directly follows bit 7, and stat_o[0] never sets.
- R6: A stop bit sampled low sets stat_o[1]. The byte is still written to the buffer.
- R7: A frame that completes while buf_full_o is high and rd_buf_i is low sets stat_o[2]. The new byte replaces the old one and buf_full_o stays high.
- R8: stat_o bits are sticky. They only clear, all together, on the clock edge after rd_stat_i is sampled high, and a bit set by a frame in that same cycle wins.
- R9: rd_buf_i high for one cycle clears buf_full_o and leaves buf_data_o unchanged.
- R10: A frame with any fault pulses irq_err_o when err_route_i is 1, and pulses irq_done_o when err_route_i is 0. A fault-free frame always pulses irq_done_o. The two outputs never pulse together.
- R11: Only one stop bit is checked. Extra high stop time is ignored, and a new start bit may begin right at the end of the first stop bit.
- R12: While the buffer stays unread, each further completed frame flags an overrun again, even after the status register has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, OVS*TICK_DIV cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| parity_mode_i | input | 2 | Parity rule: 0 none, 1 even, 2 odd, 3 zero |
| err_route_i | input | 1 | 1 routes faulty frames to irq_err_o |
| rd_buf_i | input | 1 | Host read strobe for the receive buffer |
| rd_stat_i | input | 1 | Host read strobe for the status register, clears it |
| buf_data_o | output | 8 | Receive buffer contents |
| buf_full_o | output | 1 | Unread byte present |
| stat_o | output | 3 | Sticky faults: bit 2 overrun, bit 1 framing, bit 0 parity |
| irq_done_o | output | 1 | One-cycle reception-complete pulse |
| irq_err_o | output | 1 | One-cycle reception-error pulse |

## Verification
Several rules are checked by assertions on every cycle. The assertions cover the single-cycle completion pulse, the buffer load and full flag after completion, the overrun flag whenever a frame lands on an unread buffer, the stickiness and clearing of the status register, the effect of a buffer read, and the exclusive, routed interrupts. Other behaviour only shows up in the bench's scenarios, which a reference model compares clock by clock. These scenarios are the bit order and the mid-bit sampling points, rejection of a short false start, every parity rule including the frame with no parity bit, a stop bit held low, frames sent back to back, and an overrun that recurs while the buffer is never read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } rx_state_e;

  localparam int ERR_W   = 3;
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_OVR = 2;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int TICK_DIV = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [1:0]        mode_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bit_o,
  output logic              stop_bit_o,
  output logic [1:0]        mode_o
);
  localparam int BIT_CLKS  = OVS * TICK_DIV;
  localparam int HALF_CLKS = BIT_CLKS / 2;
  localparam int CNT_W     = $clog2(BIT_CLKS);
  localparam int IDX_W     = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_BIT_END  = CNT_W'(BIT_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_HALF_END = CNT_W'(HALF_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_DATA_END = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] IDX_PAR_STOP = IDX_W'(DATA_W + 1);

  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  par_mode_e         mode_q;
  logic [DATA_W-1:0] data_q;
  logic              par_q, stop_q, done_q;
  logic [IDX_W-1:0]  stop_idx;

  // stop position depends on whether a parity bit is carried
  assign stop_idx = (mode_q == PAR_NONE) ? IDX_DATA_END : IDX_PAR_STOP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      mode_q <= PAR_NONE;
      data_q <= '0;
      par_q  <= 1'b0;
      stop_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          idx_q <= '0;
          if (!rx_i) begin
            st_q   <= ST_START;
            mode_q <= par_mode_e'(mode_i);
          end
        end
        ST_START: begin
          if (cnt_q == CNT_HALF_END) begin
            cnt_q <= '0;
            st_q  <= rx_i ? ST_IDLE : ST_BITS;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_BITS: begin
          if (cnt_q == CNT_BIT_END) begin
            cnt_q <= '0;
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == stop_idx) begin
              stop_q <= rx_i;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else if (idx_q < IDX_DATA_END) begin
              data_q <= {rx_i, data_q[DATA_W-1:1]};
            end else begin
              par_q <= rx_i;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign data_o     = data_q;
  assign par_bit_o  = par_q;
  assign stop_bit_o = stop_q;
  assign mode_o     = mode_q;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_idx_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BITS) |-> (idx_q <= stop_idx));

  assert_done_leaves_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (st_q != ST_BITS));
endmodule

// File: rtl/uart_rx_check.sv
module uart_rx_check
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic              stop_bit_i,
  input  logic [1:0]        mode_i,
  output logic              par_err_o,
  output logic              frm_err_o
);
  always_comb begin
    unique case (par_mode_e'(mode_i))
      PAR_EVEN: par_err_o = ^{data_i, par_bit_i};
      PAR_ODD:  par_err_o = ~^{data_i, par_bit_i};
      PAR_ZERO: par_err_o = par_bit_i;
      default:  par_err_o = 1'b0;
    endcase
  end

  // one stop bit only; anything after it is never examined
  assign frm_err_o = ~stop_bit_i;
endmodule

// File: rtl/uart_rx_hostregs.sv
module uart_rx_hostregs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              rd_buf_i,
  input  logic              rd_stat_i,
  input  logic              err_route_i,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              buf_full_o,
  output logic [ERR_W-1:0]  stat_o,
  output logic              irq_done_o,
  output logic              irq_err_o
);
  logic [DATA_W-1:0] buf_q;
  logic              full_q;
  logic [ERR_W-1:0]  stat_q, new_err, stat_base;
  logic              irq_done_q, irq_err_q;

  always_comb begin
    new_err          = '0;
    new_err[ERR_PAR] = par_err_i;
    new_err[ERR_FRM] = frm_err_i;
    new_err[ERR_OVR] = full_q & ~rd_buf_i;
    stat_base        = rd_stat_i ? '0 : stat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      full_q     <= 1'b0;
      stat_q     <= '0;
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
    end else begin
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
      if (done_i) begin
        buf_q  <= data_i;
        full_q <= 1'b1;
        stat_q <= stat_base | new_err;
        if ((|new_err) && err_route_i) irq_err_q  <= 1'b1;
        else                           irq_done_q <= 1'b1;
      end else begin
        stat_q <= stat_base;
        if (rd_buf_i) full_q <= 1'b0;
      end
    end
  end

  assign buf_data_o = buf_q;
  assign buf_full_o = full_q;
  assign stat_o     = stat_q;
  assign irq_done_o = irq_done_q;
  assign irq_err_o  = irq_err_q;

  assert_load_on_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (buf_full_o && (buf_data_o == $past(data_i))));

  assert_overrun_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && buf_full_o && !rd_buf_i) |=> stat_o[ERR_OVR]);

  assert_stat_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !done_i) |=> (stat_o == '0));

  assert_stat_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  assert_buf_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_buf_i && !done_i) |=> (!buf_full_o && $stable(buf_data_o)));

  assert_irq_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_done_o && irq_err_o));

  assert_err_routed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && err_route_i && (par_err_i || frm_err_i || (buf_full_o && !rd_buf_i)))
      |=> irq_err_o);

  assert_err_has_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o |-> (stat_o != '0));
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int TICK_DIV    = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [1:0]        parity_mode_i,
  input  logic              err_route_i,
  input  logic              rd_buf_i,
  input  logic              rd_stat_i,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              buf_full_o,
  output logic [ERR_W-1:0]  stat_o,
  output logic              irq_done_o,
  output logic              irq_err_o
);
  logic              rx_s;
  logic              done;
  logic [DATA_W-1:0] data;
  logic              par_bit, stop_bit, par_err, frm_err;
  logic [1:0]        frame_mode;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_frame #(.OVS(OVS), .TICK_DIV(TICK_DIV), .DATA_W(DATA_W)) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_s),
    .mode_i    (parity_mode_i),
    .done_o    (done),
    .data_o    (data),
    .par_bit_o (par_bit),
    .stop_bit_o(stop_bit),
    .mode_o    (frame_mode)
  );

  uart_rx_check #(.DATA_W(DATA_W)) i_check (
    .data_i    (data),
    .par_bit_i (par_bit),
    .stop_bit_i(stop_bit),
    .mode_i    (frame_mode),
    .par_err_o (par_err),
    .frm_err_o (frm_err)
  );

  uart_rx_hostregs #(.DATA_W(DATA_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .data_i     (data),
    .par_err_i  (par_err),
    .frm_err_i  (frm_err),
    .rd_buf_i   (rd_buf_i),
    .rd_stat_i  (rd_stat_i),
    .err_route_i(err_route_i),
    .buf_data_o (buf_data_o),
    .buf_full_o (buf_full_o),
    .stat_o     (stat_o),
    .irq_done_o (irq_done_o),
    .irq_err_o  (irq_err_o)
  );

  assert_no_parity_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && (frame_mode == 2'd0) && !rd_stat_i && !stat_o[ERR_PAR]) |=> !stat_o[ERR_PAR]);
endmodule

// File: tb/test_uart_rx_err.sv
`timescale 1ns/1ps
module test_uart_rx_err;
  localparam int OVS  = 16;
  localparam int DIV  = 4;
  localparam int BIT  = OVS * DIV;
  localparam int HALF = BIT / 2;

  typedef struct {
    int       cyc;
    bit [7:0] data;
    bit       par;
    bit       frm;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] pmode = 2'd0;
  logic       route = 1'b0;
  logic       rd_buf = 1'b0;
  logic       rd_stat = 1'b0;
  logic [7:0] buf_data;
  logic       buf_full;
  logic [2:0] stat;
  logic       irq_done, irq_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit rd_buf_q = 0, rd_stat_q = 0;
  bit finished = 0;
  int seen_done = 0, seen_err = 0;

  ev_t evq[$];
  bit [7:0] exp_data = '0;
  bit       exp_full = 0;
  bit [2:0] exp_stat = '0;

  uart_rx_err #(.OVS(OVS), .TICK_DIV(DIV)) i_uart_rx_err (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .rx_i         (rx),
    .parity_mode_i(pmode),
    .err_route_i  (route),
    .rd_buf_i     (rd_buf),
    .rd_stat_i    (rd_stat),
    .buf_data_o   (buf_data),
    .buf_full_o   (buf_full),
    .stat_o       (stat),
    .irq_done_o   (irq_done),
    .irq_err_o    (irq_err)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    rd_buf_q = rd_buf;
    rd_stat_q = rd_stat;
  end

  // reference model, compared on every clock
  always @(negedge clk) begin
    bit e_done, e_err, ovr;
    ev_t ev;
    e_done = 0;
    e_err = 0;
    if (rst_ni) begin
      if (rd_buf_q)  exp_full = 0;
      if (rd_stat_q) exp_stat = '0;
      while (evq.size() > 0 && evq[0].cyc == cyc) begin
        ev = evq.pop_front();
        ovr = exp_full;
        exp_data = ev.data;
        exp_full = 1;
        exp_stat = exp_stat | {ovr, ev.frm, ev.par};
        if ((ovr || ev.frm || ev.par) && route) e_err = 1;
        else e_done = 1;
      end
      chk("R9",  "buf_full",  buf_full, exp_full);
      chk("R2",  "buf_data",  buf_data, exp_data);
      chk("R8",  "stat",      stat,     exp_stat);
      chk("R10", "irq_done",  irq_done, e_done);
      chk("R10", "irq_err",   irq_err,  e_err);
      if (irq_done) seen_done++;
      if (irq_err)  seen_err++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // starts and ends at a negedge; the stop bit ends exactly BIT cycles after it starts
  task automatic send_frame(input bit [7:0] d, input bit badpar, input bit stop_ok, input int extra);
    bit par;
    int nb;
    ev_t e;
    nb = (pmode == 2'd0) ? 9 : 10;
    case (pmode)
      2'd1:    par = ^d;
      2'd2:    par = ~^d;
      default: par = 1'b0;
    endcase
    if (badpar) par = ~par;
    rx = 1'b0;
    e.cyc = cyc + 4 + HALF + BIT * nb;
    e.data = d;
    e.par = badpar && (pmode != 2'd0);
    e.frm = !stop_ok;
    evq.push_back(e);
    idle(BIT);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      idle(BIT);
    end
    if (nb == 10) begin
      rx = par;
      idle(BIT);
    end
    rx = stop_ok;
    idle(BIT);
    rx = 1'b1;
    idle(BIT * extra);
  endtask

  task automatic read_buf();
    rd_buf = 1'b1;
    @(negedge clk);
    rd_buf = 1'b0;
  endtask

  task automatic read_stat();
    rd_stat = 1'b1;
    @(negedge clk);
    rd_stat = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d0, e0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "reset full", buf_full, 0);
    chk("R1", "reset stat", stat, 0);
    chk("R1", "reset data", buf_data, 0);
    chk("R1", "reset irqs", {irq_done, irq_err}, 0);
    idle(BIT);

    // even parity, clean frames
    pmode = 2'd1;
    send_frame(8'hA5, 0, 1, 1);
    chk("R2", "byte A5", buf_data, 8'hA5);
    chk("R2", "full after frame", buf_full, 1);
    read_buf();
    chk("R9", "full cleared", buf_full, 0);
    chk("R9", "data kept", buf_data, 8'hA5);
    send_frame(8'h01, 0, 1, 1);
    chk("R2", "lsb first", buf_data, 8'h01);
    read_buf();

    // parity faults under every rule
    send_frame(8'h3C, 1, 1, 1);
    chk("R4", "even bad parity", stat, 3'b001);
    read_stat();
    chk("R8", "stat cleared by read", stat, 0);
    read_buf();
    pmode = 2'd2;
    send_frame(8'h81, 0, 1, 1);
    chk("R4", "odd good", stat, 3'b000);
    read_buf();
    send_frame(8'h7E, 1, 1, 1);
    chk("R4", "odd bad", stat, 3'b001);
    read_stat(); read_buf();
    pmode = 2'd3;
    send_frame(8'hFF, 0, 1, 1);
    chk("R4", "zero good", stat, 3'b000);
    read_buf();
    send_frame(8'h00, 1, 1, 1);
    chk("R4", "zero bad", stat, 3'b001);
    read_stat(); read_buf();

    // no parity bit
    pmode = 2'd0;
    send_frame(8'h55, 0, 1, 1);
    chk("R5", "none byte", buf_data, 8'h55);
    chk("R5", "none no flag", stat, 3'b000);
    read_buf();

    // framing fault, routed both ways
    pmode = 2'd1;
    d0 = seen_done;
    send_frame(8'hC3, 0, 0, 2);
    chk("R6", "framing flag", stat, 3'b010);
    chk("R6", "byte kept on framing", buf_data, 8'hC3);
    chk("R10", "route0 uses done irq", seen_done - d0, 1);
    read_stat(); read_buf();
    route = 1'b1;
    e0 = seen_err;
    d0 = seen_done;
    send_frame(8'h5A, 1, 1, 1);
    chk("R10", "route1 err irq", seen_err - e0, 1);
    chk("R10", "route1 no done irq", seen_done - d0, 0);
    read_stat(); read_buf();
    d0 = seen_done;
    send_frame(8'h96, 0, 1, 1);
    chk("R10", "clean frame done irq", seen_done - d0, 1);
    read_buf();
    route = 1'b0;

    // false start
    d0 = seen_done;
    rx = 1'b0;
    idle(BIT / 4);
    rx = 1'b1;
    idle(2 * BIT);
    chk("R3", "glitch no irq", seen_done - d0, 0);
    chk("R3", "glitch no full", buf_full, 0);
    chk("R3", "glitch data", buf_data, 8'h96);

    // overrun and its persistence
    send_frame(8'h11, 0, 1, 1);
    send_frame(8'h22, 0, 1, 1);
    chk("R7", "overrun flag", stat, 3'b100);
    chk("R7", "overwrite", buf_data, 8'h22);
    chk("R7", "still full", buf_full, 1);
    read_stat();
    send_frame(8'h33, 0, 1, 1);
    chk("R12", "overrun recurs", stat, 3'b100);
    read_stat();
    read_buf();
    send_frame(8'h44, 0, 1, 1);
    chk("R12", "no overrun after read", stat, 3'b000);
    read_buf();

    // back to back, single stop bit, then long stop
    send_frame(8'hE7, 0, 1, 0);
    fork
      send_frame(8'h18, 0, 1, 3);
      begin
        idle(3 * BIT);
        chk("R11", "first of pair", buf_data, 8'hE7);
        read_buf();
      end
    join
    chk("R11", "second of pair", buf_data, 8'h18);
    chk("R11", "no fault", stat, 3'b000);
    read_buf();
    idle(BIT);
    finish_run();
  end
endmodule